// File: doc/BRIEF.md
# Vertical-Crosswise Column Multiplier

This block multiplies two unsigned operands and forms the double-width product one output column at a time. For output position k, it adds every single-bit product a[i]·b[j] with i + j = k. It then adds the multi-bit carry handed up from column k−1. The least significant bit of that column total is product bit k. The remaining upper bits of the total go forward as the carry into column k+1. The carry that leaves the top column is the most significant product bit.

The operand width is a parameter, with a default of 4. The carry width between columns is worked out at elaboration from the largest total any column can reach. A parameter picks one of two variants: a purely combinational path, or a variant that captures the product in an output register with synchronous reset, for timing measurement. The same port list serves both variants. The clock and reset are only used by the registered variant.

Top module: `vc_mult`

## Requirements
- R1: Product bit 0 equals op_a[0] AND op_b[0]; column 0 receives no incoming carry.
- R2: For every column k from 1 to 2W−2, product bit k is bit 0 of the sum of all op_a[i]·op_b[j] with i+j=k plus the carry from column k−1; the rest of that sum, shifted right by one, is the carry into column k+1.
- R3: Carries between columns are wide enough never to lose information; with W=4 they are 2 bits. All-ones operands (1111 × 1111), where column 3 totals 6, give 11100001.
- R4: The top product bit (bit 2W−1) is the carry out of column 2W−2, so the product is exactly 2W bits wide. The product equals op_a × op_b for every operand pair; with W=4 that is all 256 pairs.
- R5: Operands 1101 and 1001 give the product 01110101.
- R6: When either operand is zero, the product is zero.
- R7: With REG_OUT=1, product shows the result for the operands present at a rising clock edge from just after that edge onward. rst high at a rising edge clears product to zero at that edge, whatever the operand values. With REG_OUT=0, product follows the operands with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset of the product register |
| op_a | input | W | Unsigned multiplicand |
| op_b | input | W | Unsigned multiplier |
| product | output | 2W | Unsigned product |

## Verification
A fault in a single column's carry cannot stay local. It shifts every higher product bit, so an error in a low column shows up as an error several times larger at the port. In the combinational variant this appears as soon as the operands settle. In the registered variant it appears right after the next clock edge. A carry that is one bit too narrow only shows when an input pair drives a middle column to its maximum total, which is why every operand pair is applied. A product register that ignores reset keeps its last non-zero value after the reset edge.

// File: rtl/vcm_pkg.sv
package vcm_pkg;

   // number of bit-products whose indices sum to column c
   function automatic int col_terms(input int w, input int c);
      int lo;
      int hi;
      lo = (c >= w) ? c - w + 1 : 0;
      hi = (c < w) ? c : w - 1;
      return (hi >= lo) ? hi - lo + 1 : 0;
   endfunction

   // largest carry value that can leave column c
   function automatic int max_carry(input int w, input int c);
      int cr;
      cr = 0;
      for (int k = 0; k <= c; k++)
         cr = (col_terms(w, k) + cr) / 2;
      return cr;
   endfunction

   // carry width needed across all columns
   function automatic int carry_bits(input int w);
      int m;
      int nb;
      m = 0;
      for (int c = 0; c < 2 * w - 1; c++)
         if (max_carry(w, c) > m)
            m = max_carry(w, c);
      nb = $clog2(m + 1);
      return (nb < 1) ? 1 : nb;
   endfunction

endpackage

// File: rtl/vcm_column.sv
module vcm_column #(
   parameter int W   = 4,
   parameter int COL = 0,
   parameter int CW  = 2
) (
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   input  logic [CW-1:0] carry_in,
   output logic          pbit,
   output logic [CW-1:0] carry_out
);
   localparam int TW   = CW + 1;
   localparam int LO   = (COL >= W) ? COL - W + 1 : 0;
   localparam int HI   = (COL < W) ? COL : W - 1;
   localparam int MAXC = vcm_pkg::max_carry(W, COL);

   if (COL < 0 || COL > 2 * W - 2) begin : g_bad_col
      $error("vcm_column: column index out of range");
   end

   logic [TW-1:0] total;

   always_comb begin
      total = TW'(carry_in);
      for (int i = LO; i <= HI; i++)
         total = total + TW'(op_a[i] & op_b[COL-i]);
   end

   assign pbit      = total[0];
   assign carry_out = total[TW-1:1];

   // R3
   always_comb begin
      if (!$isunknown({op_a, op_b, carry_in})) begin
         carry_bound_chk: assert (carry_out <= CW'(MAXC))
            else $error("column %0d carry %0d exceeds bound %0d", COL, carry_out, MAXC);
      end
   end

endmodule

// File: rtl/vcm_core.sv
module vcm_core #(
   parameter int W  = 4,
   parameter int CW = vcm_pkg::carry_bits(W)
) (
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic [2*W-1:0] product
);
   localparam int NCOL = 2 * W - 1;

   if (W < 1) begin : g_bad_w
      $error("vcm_core: operand width must be at least 1");
   end
   if (CW < vcm_pkg::carry_bits(W)) begin : g_bad_cw
      $error("vcm_core: carry width too small for this operand width");
   end

   logic [CW-1:0] cc [NCOL+1];

   assign cc[0] = '0;

   for (genvar c = 0; c < NCOL; c++) begin : g_col
      vcm_column #(.W(W), .COL(c), .CW(CW)) u_col (
         .op_a      (op_a),
         .op_b      (op_b),
         .carry_in  (cc[c]),
         .pbit      (product[c]),
         .carry_out (cc[c+1])
      );
   end

   assign product[2*W-1] = cc[NCOL][0];

   always_comb begin
      if (!$isunknown({op_a, op_b})) begin
         // R4
         no_overflow_chk: assert (cc[NCOL] <= CW'(1))
            else $error("top carry %0d does not fit one bit", cc[NCOL]);
         // R1
         lsb_and_chk: assert (product[0] == (op_a[0] & op_b[0]))
            else $error("product bit 0 mismatch");
         // R6
         zero_operand_chk: assert (!(op_a == '0 || op_b == '0) || product == '0)
            else $error("zero operand gave non-zero product");
      end
   end

endmodule

// File: rtl/vcm_out_reg.sv
module vcm_out_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else
         q <= d;
   end
endmodule

// File: rtl/vc_mult.sv
module vc_mult #(
   parameter int W       = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [W-1:0]   op_a,
   input  logic [W-1:0]   op_b,
   output logic [2*W-1:0] product
);
   localparam int PW = 2 * W;

   logic [PW-1:0] comb_prod;

   vcm_core #(.W(W)) u_core (
      .op_a    (op_a),
      .op_b    (op_b),
      .product (comb_prod)
   );

   if (REG_OUT) begin : g_reg
      vcm_out_reg #(.DW(PW)) u_oreg (
         .clk (clk),
         .rst (rst),
         .d   (comb_prod),
         .q   (product)
      );

      // R7
      reset_clear_chk: assert property (@(posedge clk) rst |=> product == '0)
         else $error("product not cleared by reset");
      // R6
      reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
         (op_a == '0 || op_b == '0) |=> product == '0)
         else $error("registered product non-zero after zero operand");
   end else begin : g_comb
      assign product = comb_prod;
   end

endmodule

// File: tb/sim_vc_mult.sv
`timescale 1ns/100ps
module sim_vc_mult;
   logic       clk;
   logic       rst;
   logic [3:0] a;
   logic [3:0] b;
   logic [7:0] p_reg;
   logic [7:0] p_comb;

   int total;
   int bad;
   bit done;
   int exp_q[$];

   vc_mult #(.W(4), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst(rst), .op_a(a), .op_b(b), .product(p_reg));
   vc_mult #(.W(4), .REG_OUT(1'b0)) u1 (
      .clk(clk), .rst(rst), .op_a(a), .op_b(b), .product(p_comb));

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input int ai, input int bi);
      int e;
      @(negedge clk);
      a = 4'(ai);
      b = 4'(bi);
      e = ai * bi;
      exp_q.push_back(e);
      #1;
      if (ai == 13 && bi == 9)
         chk("R5 1101x1001", p_comb, 8'b01110101);
      else if (ai == 15 && bi == 15)
         chk("R3 all-ones column carry", p_comb, 8'b11100001);
      else if (ai == 0 || bi == 0)
         chk("R6 zero operand", p_comb, 0);
      else
         chk("R4 comb product", p_comb, e);
      chk("R1 bit0", p_comb[0], e & 1);
      chk("R2 bit3", p_comb[3], (e >> 3) & 1);
      chk("R4 bit7", p_comb[7], (e >> 7) & 1);
   endtask

   // monitor: registered result appears just after the capturing edge
   always @(posedge clk) begin
      int e;
      #1;
      if (!rst && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         chk("R7 registered product", p_reg, e);
      end
   end

   initial begin
      total = 0;
      bad = 0;
      done = 1'b0;
      rst = 1'b1;
      a = 4'hF;
      b = 4'hF;
      repeat (3) @(posedge clk);
      #1 chk("R7 reset clears", p_reg, 0);
      @(negedge clk);
      rst = 1'b0;
      for (int ai = 0; ai < 16; ai++)
         for (int bi = 0; bi < 16; bi++)
            drive(ai, bi);
      repeat (3) @(posedge clk);
      chk("R7 queue drained", exp_q.size(), 0);
      // reset during operation with non-zero operands
      @(negedge clk);
      a = 4'hF;
      b = 4'hE;
      @(posedge clk);
      #1 chk("R7 pre-reset value", p_reg, 210);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1 chk("R7 mid-run reset", p_reg, 0);
      @(negedge clk);
      rst = 1'b0;
      drive(13, 9);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule